// File: doc/BRIEF.md
# Serial Command Key Decoder

This block is the digital front end of a four-wire serial port made of a serial clock, a data input, a latch-enable line and a data output. Data enters a 24-bit first-in first-out shift register on every rising edge of the serial clock. The host selects an action by holding the latch-enable line high for a chosen number of serial clock rising edges. When latch-enable falls, the block turns that edge count into a command. Commands latch the display word, write or read back the configuration and gain words, fire strobes to a downstream fault sequencer, or load the thermal-alert status into the shift register so that it can be shifted out.

The serial pins are treated as slow, asynchronous inputs. They are resynchronised into the system clock domain and edge-detected there. The system clock must run several times faster than the serial clock. One configuration bit moves the serial output update from the rising edge of the serial clock to the falling edge, for daisy chains with mismatched routing delays. A second configuration bit enables an automatic power-save state, which is entered when an all-zero display word is latched.

Top module: `serial_key_front`

## Requirements
- R1: On each serial-clock rising edge the sampled data input enters bit 0 of the 24-bit shift register and every other bit moves one place up. After 24 edges the first bit sent is in bit 23, which is the bit presented on `ser_dout`.
- R2: An edge count of 1 or 2 copies the shift register to `latch_data` and pulses `latch_stb` high for exactly one system clock.
- R3: Counts of 3 or 4 write the shift register into `cfg_word`. Counts of 7 or 8 write it into `gain_word`, of which only bits 17:0 (three 6-bit colour fields) are stored and bits 23:18 always read 0.
- R4: A count of 5 or 6 (configuration) or 9 or 10 (gain) loads that word into the shift register. The next 24 rising edges then present bit 23 first and bit 0 last on `ser_dout`.
- R5: Counts of 11, 12 and 13 each produce a single one-cycle pulse on `fault_req` bit 0, bit 1 and bit 2 respectively. These are the open, short and combined requests.
- R6: A count of 14 pulses `therm_stb` once and loads the shift register with all ones if `over_temp` is 1, or with all zeros otherwise.
- R7: Counts of 0, 15, 16 and anything above 16 change no register and raise no strobe.
- R8: With `cfg_word` bit 7 at 0, `ser_dout` takes the newly shifted bit right after a rising edge. With bit 7 at 1, `ser_dout` keeps its value through the high phase and takes the new bit after the following falling edge.
- R9: With `cfg_word` bit 6 at 1, latching an all-zero word sets `power_save`. In power save every command is ignored except a latch of a word with at least one 1, which is latched and clears `power_save`. With bit 6 at 0, latching zeros leaves `power_save` at 0.
- R10: After reset, `cfg_word` is 0, `gain_word` is 0x001041 (each colour field equals 1), `latch_data` is 0, `power_save` is 0 and `ser_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data input |
| ser_le | input | 1 | Latch-enable line; its high time in edges selects the command |
| over_temp | input | 1 | Over-temperature flag from the thermal sensor |
| ser_dout | output | 1 | Serial data output (bit 23 of the shift path) |
| latch_data | output | 24 | Latched display word for the output drivers |
| latch_stb | output | 1 | One-cycle pulse when `latch_data` is updated |
| cfg_word | output | 24 | Configuration register |
| gain_word | output | 24 | Gain register (three 6-bit fields in bits 17:0) |
| fault_req | output | 3 | One-hot detection requests: open, short, combined |
| therm_stb | output | 1 | One-cycle pulse on a thermal-alert read |
| power_save | output | 1 | Auto power-save state |

## Verification
A corrupted edge counter or a wrong decode shows up within a few system clocks of latch-enable falling. It appears as the wrong strobe, a missing strobe, or a register that changes when it should hold. A wrong shift or load path is visible on `ser_dout` at the first bit of a read-back, and it is checked bit by bit over the next 24 serial edges. A wrong output-timing mode shows mid-way through the high phase of the serial clock. A stuck or missed power-save state shows as a command taking effect, or failing to, on the very next key.

// File: rtl/skd_pkg.sv
package skd_pkg;

   typedef enum logic [3:0] {
      KEY_NONE,
      KEY_LATCH,
      KEY_WR_CFG,
      KEY_RD_CFG,
      KEY_WR_GAIN,
      KEY_RD_GAIN,
      KEY_DET_OPEN,
      KEY_DET_SHORT,
      KEY_DET_BOTH,
      KEY_THERMAL
   } key_e;

   localparam int FAULT_W = 3;

   function automatic key_e key_of(input int unsigned edges);
      case (edges)
         1, 2:    return KEY_LATCH;
         3, 4:    return KEY_WR_CFG;
         5, 6:    return KEY_RD_CFG;
         7, 8:    return KEY_WR_GAIN;
         9, 10:   return KEY_RD_GAIN;
         11:      return KEY_DET_OPEN;
         12:      return KEY_DET_SHORT;
         13:      return KEY_DET_BOTH;
         14:      return KEY_THERMAL;
         default: return KEY_NONE;
      endcase
   endfunction

endpackage

// File: rtl/skd_sync.sv
module skd_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("skd_sync: STAGES must be at least 1");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_st
      logic [W-1:0] r;
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= g_st[s-1].r;
         end
      end
   end

   assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/skd_shift.sv
module skd_shift #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("skd_shift: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load_en)  q <= load_val;
      else if (shift_en) q <= {q[W-2:0], din};
   end

   // R1: a shift places the sampled input at the bottom and moves the rest up
   assert_shift_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !load_en) |=> (q[0] == $past(din)) && (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/skd_keydec.sv
module skd_keydec
   import skd_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise_evt,
   input  logic le_lvl,
   input  logic le_fall,
   output key_e key_q,
   output logic key_vld
);
   if (CNT_W < 5) begin : g_bad_cnt
      $error("skd_keydec: CNT_W must hold counts above 16");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         key_q    <= KEY_NONE;
         key_vld  <= 1'b0;
      end else begin
         key_vld <= le_fall;
         if (le_fall) begin
            key_q    <= key_of(int'(edge_cnt));
            edge_cnt <= '0;
         end else if (rise_evt && le_lvl && edge_cnt != CNT_MAX) begin
            edge_cnt <= edge_cnt + 1'b1;
         end
      end
   end

   // R2: one latch-enable release yields one decode cycle
   assert_key_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |=> !key_vld);

   // R7: the count is cleared on every decode
   assert_cnt_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      le_fall |=> (edge_cnt == '0));
endmodule

// File: rtl/skd_regs.sv
module skd_regs
   import skd_pkg::*;
#(
   parameter int W         = 24,
   parameter int GAIN_W    = 6,
   parameter int NCOL      = 3,
   parameter int PSAVE_BIT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               key_vld,
   input  key_e               key,
   input  logic [W-1:0]       sr,
   input  logic               over_temp,
   output logic [W-1:0]       cfg_q,
   output logic [W-1:0]       gain_q,
   output logic [W-1:0]       latch_q,
   output logic               latch_stb,
   output logic [FAULT_W-1:0] fault_req,
   output logic               therm_stb,
   output logic               psave,
   output logic               load_en,
   output logic [W-1:0]       load_val
);
   localparam int GBITS = NCOL * GAIN_W;

   if (GBITS > W) begin : g_bad_gain
      $error("skd_regs: gain fields exceed the word width");
   end
   if (PSAVE_BIT >= W) begin : g_bad_psave
      $error("skd_regs: PSAVE_BIT out of range");
   end

   function automatic logic [W-1:0] gain_init();
      logic [W-1:0] v;
      v = '0;
      for (int c = 0; c < NCOL; c++) v[c*GAIN_W] = 1'b1;
      return v;
   endfunction

   localparam logic [W-1:0] GAIN_RST  = gain_init();
   localparam logic [W-1:0] GAIN_MASK = (W'(1) << GBITS) - W'(1);

   logic sr_any;
   logic cmd_ok;
   logic latch_ok;

   assign sr_any   = |sr;
   assign cmd_ok   = key_vld && !psave;
   assign latch_ok = key_vld && (key == KEY_LATCH) && (!psave || sr_any);

   always_comb begin
      load_en  = 1'b0;
      load_val = '0;
      if (cmd_ok) begin
         case (key)
            KEY_RD_CFG:  begin load_en = 1'b1; load_val = cfg_q;  end
            KEY_RD_GAIN: begin load_en = 1'b1; load_val = gain_q; end
            KEY_THERMAL: begin load_en = 1'b1; load_val = over_temp ? '1 : '0; end
            default:     ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q     <= '0;
         gain_q    <= GAIN_RST;
         latch_q   <= '0;
         latch_stb <= 1'b0;
         fault_req <= '0;
         therm_stb <= 1'b0;
         psave     <= 1'b0;
      end else begin
         latch_stb <= 1'b0;
         fault_req <= '0;
         therm_stb <= 1'b0;
         if (latch_ok) begin
            latch_q   <= sr;
            latch_stb <= 1'b1;
            psave     <= cfg_q[PSAVE_BIT] && !sr_any;
         end
         if (cmd_ok) begin
            case (key)
               KEY_WR_CFG:    cfg_q        <= sr;
               KEY_WR_GAIN:   gain_q       <= sr & GAIN_MASK;
               KEY_DET_OPEN:  fault_req[0] <= 1'b1;
               KEY_DET_SHORT: fault_req[1] <= 1'b1;
               KEY_DET_BOTH:  fault_req[2] <= 1'b1;
               KEY_THERMAL:   therm_stb    <= 1'b1;
               default:       ;
            endcase
         end
      end
   end

   // R9: while power save holds, the configuration and gain words are frozen
   assert_psave_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (psave && $past(psave)) |-> ($stable(cfg_q) && $stable(gain_q)));

   // R5: at most one strobe of any kind per cycle
   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({latch_stb, fault_req, therm_stb}));

   // R2: latched word only moves together with its strobe
   assert_latch_with_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_stb |-> (latch_q == $past(latch_q)) || $past(latch_ok));
endmodule

// File: rtl/serial_key_front.sv
module serial_key_front
   import skd_pkg::*;
#(
   parameter int DATA_W    = 24,
   parameter int GAIN_W    = 6,
   parameter int NCOL      = 3,
   parameter int SYNC_N    = 2,
   parameter int CNT_W     = 5,
   parameter int PSAVE_BIT = 6,
   parameter int SDO_BIT   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   input  logic              ser_le,
   input  logic              over_temp,
   output logic              ser_dout,
   output logic [DATA_W-1:0] latch_data,
   output logic              latch_stb,
   output logic [DATA_W-1:0] cfg_word,
   output logic [DATA_W-1:0] gain_word,
   output logic [2:0]        fault_req,
   output logic              therm_stb,
   output logic              power_save
);
   if (SDO_BIT >= DATA_W) begin : g_bad_sdo
      $error("serial_key_front: SDO_BIT out of range");
   end

   localparam int NPIN = 3;

   logic [NPIN-1:0]   pins_s;
   logic              s_clk, s_din, s_le;
   logic              d_clk, d_le;
   logic              rise_evt, fall_evt, le_fall;
   key_e              key;
   logic              key_vld;
   logic [DATA_W-1:0] sr;
   logic              load_en;
   logic [DATA_W-1:0] load_val;
   logic              fall_mode;
   logic              hold_upd;
   logic              sdo_hold;

   skd_sync #(.W(NPIN), .STAGES(SYNC_N)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_clk, ser_din, ser_le}),
      .q    (pins_s)
   );

   assign {s_clk, s_din, s_le} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         d_clk <= 1'b0;
         d_le  <= 1'b0;
      end else begin
         d_clk <= s_clk;
         d_le  <= s_le;
      end
   end

   assign rise_evt = s_clk & ~d_clk;
   assign fall_evt = ~s_clk & d_clk;
   assign le_fall  = ~s_le & d_le;

   skd_keydec #(.CNT_W(CNT_W)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_evt(rise_evt),
      .le_lvl  (s_le),
      .le_fall (le_fall),
      .key_q   (key),
      .key_vld (key_vld)
   );

   skd_shift #(.W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(rise_evt),
      .din     (s_din),
      .load_en (load_en),
      .load_val(load_val),
      .q       (sr)
   );

   skd_regs #(
      .W        (DATA_W),
      .GAIN_W   (GAIN_W),
      .NCOL     (NCOL),
      .PSAVE_BIT(PSAVE_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_vld  (key_vld),
      .key      (key),
      .sr       (sr),
      .over_temp(over_temp),
      .cfg_q    (cfg_word),
      .gain_q   (gain_word),
      .latch_q  (latch_data),
      .latch_stb(latch_stb),
      .fault_req(fault_req),
      .therm_stb(therm_stb),
      .psave    (power_save),
      .load_en  (load_en),
      .load_val (load_val)
   );

   assign fall_mode = cfg_word[SDO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_upd <= 1'b0;
         sdo_hold <= 1'b0;
      end else begin
         hold_upd <= fall_evt | load_en;
         if (hold_upd) sdo_hold <= sr[DATA_W-1];
      end
   end

   assign ser_dout = fall_mode ? sdo_hold : sr[DATA_W-1];

   // R8: in falling-edge mode the output only moves just after a falling edge or a load
   assert_sdo_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_mode && $past(fall_mode) && !$past(hold_upd)) |-> $stable(ser_dout));
endmodule

// File: tb/sim_serial_key_front.sv
`timescale 1ns/1ps
module sim_serial_key_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_din = 1'b0, ser_le = 1'b0, over_temp = 1'b0;
   logic        ser_dout;
   logic [23:0] latch_data, cfg_word, gain_word;
   logic        latch_stb, therm_stb, power_save;
   logic [2:0]  fault_req;

   int n_chk = 0, n_fail = 0;
   int n_latch = 0, n_therm = 0;
   int n_fault [3] = '{0, 0, 0};

   bit    exp_q[$];
   string sb_tag;
   event  smp;

   always #2.5 clk = ~clk;

   serial_key_front u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din), .ser_le(ser_le),
      .over_temp(over_temp), .ser_dout(ser_dout), .latch_data(latch_data),
      .latch_stb(latch_stb), .cfg_word(cfg_word), .gain_word(gain_word),
      .fault_req(fault_req), .therm_stb(therm_stb), .power_save(power_save)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pops each expected serial bit and compares with the pin
   always @(smp) begin
      bit e;
      e = exp_q.pop_front();
      chk(sb_tag, {31'd0, ser_dout}, {31'd0, e});
   end

   always @(negedge clk) begin
      if (latch_stb) n_latch++;
      if (therm_stb) n_therm++;
      for (int b = 0; b < 3; b++) if (fault_req[b]) n_fault[b]++;
   end

   task automatic bit_clk();
      repeat (6) @(negedge clk);
      ser_clk = 1'b1;
      repeat (6) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   // shifts a word MSB first; latch-enable is high for the last 'key' edges
   task automatic send(input logic [23:0] w, input int key);
      for (int i = 23; i >= 0; i--) begin
         ser_din = w[i];
         ser_le  = (i < key);
         bit_clk();
      end
      repeat (2) @(negedge clk);
      ser_le  = 1'b0;
      ser_din = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   task automatic le_pulse();
      ser_le = 1'b1;
      repeat (6) @(negedge clk);
      ser_le = 1'b0;
      repeat (8) @(negedge clk);
   endtask

   // driver side of the scoreboard: pushes the expected stream, samples before each rise
   task automatic readout(input logic [23:0] w, input string tag, input bit fall);
      sb_tag = tag;
      for (int i = 0; i < 24; i++) begin
         logic nxt;
         repeat (6) @(negedge clk);
         exp_q.push_back(w[23-i]);
         ->smp;
         @(negedge clk);
         ser_clk = 1'b1;
         repeat (7) @(negedge clk);
         nxt = (i < 23) ? w[22-i] : 1'b0;
         chk({tag, " mid-high R8"}, {31'd0, ser_dout}, {31'd0, fall ? w[23-i] : nxt});
         ser_ser_low();
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic ser_ser_low();
      ser_clk = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int l0, f0, f1, f2, t0;
      repeat (4) @(negedge clk);
      // R10 reset state
      chk("R10 cfg", {8'd0, cfg_word}, 32'h0);
      chk("R10 gain", {8'd0, gain_word}, 32'h001041);
      chk("R10 latch", {8'd0, latch_data}, 32'h0);
      chk("R10 psave", {31'd0, power_save}, 32'h0);
      chk("R10 sdo", {31'd0, ser_dout}, 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1/R2 latch with one and two edges
      l0 = n_latch;
      send(24'hA5C33C, 1);
      chk("R2 latch key1", {8'd0, latch_data}, 32'hA5C33C);
      chk("R2 one strobe", n_latch - l0, 1);
      send(24'h3C0F81, 2);
      chk("R2 latch key2", {8'd0, latch_data}, 32'h3C0F81);

      // R9 zeros latched with power save disabled
      send(24'h000000, 1);
      chk("R9 no psave when disabled", {31'd0, power_save}, 32'h0);

      // R3 configuration write and R4 read back
      send(24'h812305, 3);
      chk("R3 cfg write", {8'd0, cfg_word}, 32'h812305);
      send(24'h000000, 5);
      readout(24'h812305, "R4 cfg readback", 1'b0);

      // R3 gain write with masked top bits, R4 read back
      send(24'hFFFFFF, 8);
      chk("R3 gain write", {8'd0, gain_word}, 32'h03FFFF);
      send(24'h000000, 10);
      readout(24'h03FFFF, "R4 gain readback", 1'b0);

      // R1 plain shift through: a data word appears after 24 edges
      send(24'h5A00F1, 0);
      readout(24'h5A00F1, "R1 shift through", 1'b0);

      // R5 fault strobes
      f0 = n_fault[0]; f1 = n_fault[1]; f2 = n_fault[2];
      send(24'h0, 11);
      send(24'h0, 12);
      send(24'h0, 13);
      chk("R5 open", n_fault[0] - f0, 1);
      chk("R5 short", n_fault[1] - f1, 1);
      chk("R5 both", n_fault[2] - f2, 1);

      // R6 thermal read both ways
      t0 = n_therm;
      over_temp = 1'b1;
      send(24'h0, 14);
      over_temp = 1'b0;
      readout(24'hFFFFFF, "R6 hot", 1'b0);
      send(24'h0, 14);
      readout(24'h000000, "R6 cool", 1'b0);
      chk("R6 strobes", n_therm - t0, 2);

      // R7 ignored counts
      l0 = n_latch; t0 = n_therm; f0 = n_fault[0] + n_fault[1] + n_fault[2];
      send(24'h00FFFF, 15);
      send(24'h00FFFF, 16);
      send(24'h00FFFF, 20);
      le_pulse();
      chk("R7 cfg kept", {8'd0, cfg_word}, 32'h812305);
      chk("R7 gain kept", {8'd0, gain_word}, 32'h03FFFF);
      chk("R7 latch kept", {8'd0, latch_data}, 32'h000000);
      chk("R7 no strobes", (n_latch - l0) + (n_therm - t0)
          + (n_fault[0] + n_fault[1] + n_fault[2] - f0), 0);

      // R8 falling-edge output mode
      send(24'h0000C6, 3);
      send(24'h0, 5);
      readout(24'h0000C6, "R8 fall mode readback", 1'b1);

      // R9 power save
      send(24'h000040, 3);
      l0 = n_latch;
      send(24'h000000, 1);
      chk("R9 enter", {31'd0, power_save}, 32'h1);
      chk("R9 enter latch", n_latch - l0, 1);
      send(24'h000080, 3);
      chk("R9 cfg write ignored", {8'd0, cfg_word}, 32'h000040);
      f0 = n_fault[0]; t0 = n_therm;
      send(24'h0, 11);
      send(24'h0, 14);
      chk("R9 fault/thermal ignored", (n_fault[0] - f0) + (n_therm - t0), 0);
      l0 = n_latch;
      send(24'h000000, 1);
      chk("R9 zero latch ignored", n_latch - l0, 0);
      chk("R9 still asleep", {31'd0, power_save}, 32'h1);
      send(24'h000100, 2);
      chk("R9 wake", {31'd0, power_save}, 32'h0);
      chk("R9 wake latch", {8'd0, latch_data}, 32'h000100);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule